// File: doc/BRIEF.md
# I2C Sampling-Converter Slave with Clock Stretching

This block is the two-wire serial front end of a 14-bit sampling converter. It watches SCL and SDA through synchronizing, glitch-filtering input stages and answers on the bus only by pulling a line low, through two open-drain enable outputs. It finds START, repeated START and STOP, and compares the first byte of each transfer with a 7-bit slave address. The upper three address bits are fixed by a parameter and the lower four come from pins. It also recognizes the high-speed master code and reports which bus speed mode is in force.

A matching address always begins a conversion, whatever the direction bit says. The block acknowledges, powers the converter, pulses a start request and keeps SCL low until the converter's done pulse. It then sends the latched result as two bytes. A master acknowledge after the second byte begins another conversion. The direction bit only chooses whether an internal reference is kept on or asked to shut down. The analog part is outside the block: a start/done handshake and a 14-bit result port.

Top module: `i2c_adc_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe, conv_power, ref_shutdown and hs_mode are all 0.
- R2: A first byte whose bits 7..1 (sent MSB first) equal {3'b011, addr_pins} is acknowledged: SDA is pulled low during the ninth SCL clock.
- R3: A first byte with any other address and no master-code pattern gets no acknowledge and no conv_start. SDA and SCL stay released for every later byte until the next START.
- R4: A first byte of the pattern 8'b00001xxx is not acknowledged. hs_mode becomes 1 after its ninth clock and stays 1 through a repeated START and the address that follows.
- R5: A STOP condition clears hs_mode to 0.
- R6: A matching address produces a one-cycle conv_start pulse. conv_power is 1 from the cycle after conv_start until the cycle after conv_done.
- R7: After an acknowledged address, SCL is held low from the ninth falling edge until a conv_done has arrived. It is released only afterwards.
- R8: The first data byte is result[13:6]. The second is {result[5:0], sub_bits[1:0]}, where both values are latched at conv_done. Each byte is sent MSB first.
- R9: A master acknowledge after the second byte starts a new conversion, stretches SCL again and returns two more bytes.
- R10: A master not-acknowledge after a data byte starts no further conversion and leaves SDA released until the next START or STOP.
- R11: On a matching address, ref_shutdown is loaded with 1 when int_ref_mode=1 and the direction bit is 0, and with 0 otherwise. Data is returned in every case.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_pins | input | 4 | Low four slave address bits |
| int_ref_mode | input | 1 | 1 = internal reference in use |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| conv_result | input | 14 | Conversion result, valid with conv_done |
| sub_bits | input | 2 | Trailing sub-bits, valid with conv_done |
| conv_power | output | 1 | Converter power-up request |
| ref_shutdown | output | 1 | Internal reference shutdown request |
| hs_mode | output | 1 | 1 = high-speed mode in force |

## Verification
If the bit counter or the protocol state goes wrong, the error appears on SDA within one byte. It shows as a missing or misplaced acknowledge, or as data bits shifted by one position in the byte the master reads next. If result latching or stretch control goes wrong, the first data clock shows it. SCL is either not stretched at all or held past conv_done, and the master measures the stretch length directly. If the speed-mode or reference state goes wrong, it is visible on hs_mode or ref_shutdown as soon as the ninth clock of the byte that should set it has completed.

// File: rtl/i2c_adc_pkg.sv
package i2c_adc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_MCODE,
    ST_CONV,
    ST_DATA,
    ST_MACK,
    ST_IGNORE
  } slv_state_e;

  localparam logic [4:0] MCODE_PREFIX = 5'b00001;

endpackage

// File: rtl/i2c_adc_sync.sv
module i2c_adc_sync #(
  parameter int STAGES = 2,
  parameter int FILT   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [STAGES-1:0] meta_q;
  logic [FILT-1:0]   hist_q;
  logic              filt_q, filt_d;

  // output moves only after FILT equal samples
  always_comb begin
    filt_d = filt_q;
    if (&hist_q)       filt_d = 1'b1;
    else if (~|hist_q) filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      meta_q <= {meta_q[STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT-2:0], meta_q[STAGES-1]};
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;

endmodule

// File: rtl/i2c_adc_cond.sv
module i2c_adc_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_o = scl & scl_q & sda_q & ~sda;
  assign stop_o  = scl & scl_q & ~sda_q & sda;
  assign rise_o  = scl & ~scl_q;
  assign fall_o  = ~scl & scl_q;

endmodule

// File: rtl/i2c_adc_fsm.sv
module i2c_adc_fsm
  import i2c_adc_pkg::*;
#(
  parameter int         RES_W   = 14,
  parameter int         SUB_W   = 2,
  parameter logic [2:0] ADDR_HI = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [3:0]       addr_pins,
  input  logic             int_ref_mode,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic [SUB_W-1:0] sub_bits,
  output logic             scl_hold,
  output logic             sda_drive,
  output logic             conv_start,
  output logic             conv_power,
  output logic             ref_shutdown,
  output logic             hs_mode
);

  localparam int FRAME_W = RES_W + SUB_W;
  localparam int BYTES   = FRAME_W / 8;
  localparam int BIDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(BYTES - 1);

  slv_state_e         state_q, state_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [7:0]         rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d, data_q, data_d;
  logic [BIDX_W-1:0]  bidx_q, bidx_d;
  logic               ready_q, ready_d, power_q, power_d, ref_q, ref_d;
  logic               hs_q, hs_d, hold_q, hold_d, drv_q, drv_d;
  logic               start_q, start_d, mack_q, mack_d;

  always_comb begin
    state_d = state_q;  cnt_d  = cnt_q;  rx_d    = rx_q;
    tx_d    = tx_q;     data_d = data_q; bidx_d  = bidx_q;
    ready_d = ready_q;  power_d = power_q; ref_d = ref_q;
    hs_d    = hs_q;     hold_d = hold_q; drv_d   = drv_q;
    start_d = 1'b0;     mack_d = mack_q;

    if (conv_done) begin
      data_d  = {conv_result, sub_bits};
      ready_d = 1'b1;
      power_d = 1'b0;
    end

    if (bus_stop) begin
      state_d = ST_IDLE; hs_d = 1'b0; hold_d = 1'b0; drv_d = 1'b0;
    end else if (bus_start) begin
      state_d = ST_ADDR; cnt_d = 4'd0; hold_d = 1'b0; drv_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_d  = {rx_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (rx_q[7:1] == {ADDR_HI, addr_pins}) begin
              state_d = ST_ACK;
              drv_d   = 1'b1;
              start_d = 1'b1;
              power_d = 1'b1;
              ready_d = 1'b0;
              ref_d   = int_ref_mode & ~rx_q[0];
            end else if (rx_q[7:3] == MCODE_PREFIX) begin
              state_d = ST_MCODE;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          drv_d = 1'b0; hold_d = 1'b1; state_d = ST_CONV;
        end
        ST_MCODE: if (scl_rise) begin
          hs_d = 1'b1; state_d = ST_IGNORE;
        end
        ST_CONV: if (ready_q) begin
          hold_d  = 1'b0;
          tx_d    = data_q;
          drv_d   = ~data_q[FRAME_W-1];
          cnt_d   = 4'd0;
          bidx_d  = '0;
          ready_d = 1'b0;
          state_d = ST_DATA;
        end
        ST_DATA: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            drv_d = 1'b0; cnt_d = 4'd0; state_d = ST_MACK;
          end else begin
            tx_d  = tx_q << 1;
            drv_d = ~tx_q[FRAME_W-2];
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (!mack_q) begin
              state_d = ST_IGNORE;
            end else if (bidx_q != LAST_BYTE) begin
              bidx_d  = bidx_q + 1'b1;
              tx_d    = tx_q << 1;
              drv_d   = ~tx_q[FRAME_W-2];
              state_d = ST_DATA;
            end else begin
              start_d = 1'b1; power_d = 1'b1; ready_d = 1'b0;
              hold_d  = 1'b1; state_d = ST_CONV;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; rx_q <= '0; tx_q <= '0; data_q <= '0;
      bidx_q <= '0; ready_q <= 1'b0; power_q <= 1'b0; ref_q <= 1'b0;
      hs_q <= 1'b0; hold_q <= 1'b0; drv_q <= 1'b0; start_q <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; rx_q <= rx_d; tx_q <= tx_d;
      data_q <= data_d; bidx_q <= bidx_d; ready_q <= ready_d;
      power_q <= power_d; ref_q <= ref_d; hs_q <= hs_d; hold_q <= hold_d;
      drv_q <= drv_d; start_q <= start_d; mack_q <= mack_d;
    end
  end

  assign scl_hold     = hold_q;
  assign sda_drive    = drv_q;
  assign conv_start   = start_q;
  assign conv_power   = power_q;
  assign ref_shutdown = ref_q;
  assign hs_mode      = hs_q;

endmodule

// File: rtl/i2c_adc_slave.sv
module i2c_adc_slave #(
  parameter int         RES_W       = 14,
  parameter int         SUB_W       = 2,
  parameter logic [2:0] ADDR_HI     = 3'b011,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic [3:0]       addr_pins,
  input  logic             int_ref_mode,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic [SUB_W-1:0] sub_bits,
  output logic             conv_power,
  output logic             ref_shutdown,
  output logic             hs_mode
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic start_c, stop_c, rise_c, fall_c;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_adc_sync #(.STAGES(SYNC_STAGES), .FILT(FILT_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(clean_lines[g])
    );
  end

  i2c_adc_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(clean_lines[0]), .sda(clean_lines[1]),
    .start_o(start_c), .stop_o(stop_c), .rise_o(rise_c), .fall_o(fall_c)
  );

  i2c_adc_fsm #(.RES_W(RES_W), .SUB_W(SUB_W), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(rise_c), .scl_fall(fall_c),
    .sda_lvl(clean_lines[1]), .bus_start(start_c), .bus_stop(stop_c),
    .addr_pins(addr_pins), .int_ref_mode(int_ref_mode),
    .conv_done(conv_done), .conv_result(conv_result), .sub_bits(sub_bits),
    .scl_hold(scl_oe), .sda_drive(sda_oe), .conv_start(conv_start),
    .conv_power(conv_power), .ref_shutdown(ref_shutdown), .hs_mode(hs_mode)
  );

endmodule

// File: rtl/i2c_adc_chk.sv
module i2c_adc_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic conv_start,
  input logic conv_done,
  input logic conv_power,
  input logic ref_shutdown,
  input logic hs_mode
);

  logic done_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_seen <= 1'b0;
    else if (conv_start) done_seen <= 1'b0;
    else if (conv_done)  done_seen <= 1'b1;
  end

  a_r12_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  a_r6_power_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> conv_power);

  a_r6_power_off_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_start) |=> !conv_power);

  a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> done_seen);

  a_r4_hs_entry_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> !sda_oe);

  a_r11_ref_moves_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_shutdown) |-> conv_start);

endmodule

bind i2c_adc_slave i2c_adc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .conv_start(conv_start), .conv_done(conv_done), .conv_power(conv_power),
  .ref_shutdown(ref_shutdown), .hs_mode(hs_mode)
);

// File: tb/tb_i2c_adc_slave.sv
module tb_i2c_adc_slave;

  localparam int HALF = 25;
  localparam int QTR  = 10;
  localparam int CONV_CYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe;
  logic [3:0] addr_pins = 4'b0101;
  logic int_ref_mode = 1'b1;
  logic conv_start, conv_done = 1'b0;
  logic [13:0] conv_result = '0;
  logic [1:0] sub_bits = '0;
  logic conv_power, ref_shutdown, hs_mode;

  int n_tests = 0, n_fail = 0, n_conv = 0, r12_viol = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_adc_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_pins(addr_pins),
    .int_ref_mode(int_ref_mode), .conv_start(conv_start),
    .conv_done(conv_done), .conv_result(conv_result), .sub_bits(sub_bits),
    .conv_power(conv_power), .ref_shutdown(ref_shutdown), .hs_mode(hs_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // converter model: result pushed into the expected queue
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        n_conv++;
        wait_cyc(CONV_CYC);
        conv_result = 14'(14'h01A5 + n_conv * 14'h0B37);
        sub_bits    = 2'(n_conv);
        exp_q.push_back({conv_result, sub_bits});
        chk(conv_power == 1'b1, "R6 power during conversion", conv_power, 1);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        chk(conv_power == 1'b0, "R6 power off after done", conv_power, 0);
      end
    end
  end

  // SDA must not move while SCL stays high
  initial begin
    logic p_scl, p_oe;
    p_scl = 1'b1; p_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && scl_line && p_scl && (sda_oe != p_oe)) r12_viol++;
      p_scl = scl_line; p_oe = sda_oe;
    end
  end

  task automatic clk_pulse(output bit smp, output int str);
    str = 0;
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_line && str < 4000) begin
      @(negedge clk);
      str++;
    end
    wait_cyc(HALF);
    smp = sda_line;
    m_scl = 1'b0;
    wait_cyc(QTR);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_cyc(HALF);
    m_scl = 1'b1; wait_cyc(HALF);
    m_sda = 1'b0; wait_cyc(HALF);
    m_scl = 1'b0; wait_cyc(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_cyc(HALF);
    m_scl = 1'b1; wait_cyc(HALF);
    m_sda = 1'b1; wait_cyc(HALF);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit s; int st;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_cyc(HALF);
      clk_pulse(s, st);
    end
    m_sda = 1'b1; wait_cyc(HALF);
    clk_pulse(s, st);
    ack = ~s;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d, output int str0);
    bit s; int st;
    m_sda = 1'b1;
    d = '0; str0 = 0;
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(HALF);
      clk_pulse(s, st);
      if (i == 7) str0 = st;
      d = {d[6:0], s};
    end
    m_sda = ~give_ack; wait_cyc(HALF);
    clk_pulse(s, st);
    m_sda = 1'b1;
  endtask

  // read one result as two bytes and compare with the converter model
  task automatic read_pair(input bit ack_last, input string tag);
    logic [7:0] b0, b1; int st0, st1; logic [15:0] f;
    read_byte(1'b1, b0, st0);
    chk(st0 > 50, {"R7 stretch before first byte ", tag}, st0, 51);
    read_byte(ack_last, b1, st1);
    if (exp_q.size() == 0) begin
      chk(1'b0, {"R8 no result available ", tag}, 0, 1);
    end else begin
      f = exp_q.pop_front();
      chk(b0 == f[15:8], {"R8 high byte ", tag}, b0, f[15:8]);
      chk(b1 == f[7:0],  {"R8 low byte with sub-bits ", tag}, b1, f[7:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit ack; int c0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1 reset state
    chk(scl_oe == 0,       "R1 scl_oe", scl_oe, 0);
    chk(sda_oe == 0,       "R1 sda_oe", sda_oe, 0);
    chk(conv_power == 0,   "R1 conv_power", conv_power, 0);
    chk(hs_mode == 0,      "R1 hs_mode", hs_mode, 0);
    chk(ref_shutdown == 0, "R1 ref_shutdown", ref_shutdown, 0);

    // R2 match, internal ref, dir=1; R9 second conversion; R10 nack
    bus_start();
    write_byte({3'b011, 4'b0101, 1'b1}, ack);
    chk(ack == 1, "R2 address acknowledged", ack, 1);
    chk(n_conv == 1, "R6 one conversion started", n_conv, 1);
    chk(ref_shutdown == 0, "R11 internal ref dir=1 keeps ref", ref_shutdown, 0);
    read_pair(1'b1, "first");
    read_pair(1'b0, "R9 repeat");
    chk(n_conv == 2, "R9 second conversion started", n_conv, 2);
    wait_cyc(300);
    chk(n_conv == 2, "R10 no conversion after nack", n_conv, 2);
    chk(sda_oe == 0, "R10 SDA released after nack", sda_oe, 0);
    bus_stop();

    // R11 internal ref, dir=0
    bus_start();
    write_byte({3'b011, 4'b0101, 1'b0}, ack);
    chk(ack == 1, "R2 ack with dir=0", ack, 1);
    chk(ref_shutdown == 1, "R11 internal ref dir=0 shuts down", ref_shutdown, 1);
    read_pair(1'b0, "R11 dir0");
    bus_stop();

    // R11 external ref, dir=0 ignored
    int_ref_mode = 1'b0;
    bus_start();
    write_byte({3'b011, 4'b0101, 1'b0}, ack);
    chk(ref_shutdown == 0, "R11 external ref ignores dir", ref_shutdown, 0);
    read_pair(1'b0, "R11 ext");
    bus_stop();
    int_ref_mode = 1'b1;

    // R3 mismatch then a would-be address later in the transfer
    c0 = n_conv;
    bus_start();
    write_byte({3'b011, 4'b0110, 1'b1}, ack);
    chk(ack == 0, "R3 wrong address not acknowledged", ack, 0);
    write_byte({3'b011, 4'b0101, 1'b1}, ack);
    chk(ack == 0, "R3 later byte ignored", ack, 0);
    chk(n_conv == c0, "R3 no conversion", n_conv, c0);
    chk(scl_oe == 0, "R3 no stretch", scl_oe, 0);
    bus_stop();

    // R4 master code, high-speed transfer, R5 stop
    bus_start();
    write_byte(8'b0000_1010, ack);
    chk(ack == 0, "R4 master code not acknowledged", ack, 0);
    chk(hs_mode == 1, "R4 high-speed mode entered", hs_mode, 1);
    bus_start();
    chk(hs_mode == 1, "R4 hs kept over repeated START", hs_mode, 1);
    write_byte({3'b011, 4'b0101, 1'b1}, ack);
    chk(ack == 1, "R4 address after master code", ack, 1);
    chk(hs_mode == 1, "R4 hs kept after address", hs_mode, 1);
    read_pair(1'b0, "R4 hs");
    bus_stop();
    wait_cyc(10);
    chk(hs_mode == 0, "R5 STOP returns to normal speed", hs_mode, 0);

    // R2 address follows pins
    addr_pins = 4'b1010;
    bus_start();
    write_byte({3'b011, 4'b1010, 1'b1}, ack);
    chk(ack == 1, "R2 new pin address acknowledged", ack, 1);
    read_pair(1'b0, "R2 pins");
    bus_stop();
    wait_cyc(50);

    chk(r12_viol == 0, "R12 SDA changes only while SCL low", r12_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule